// File: doc/BRIEF.md
# DMA Auto-Request Bus Ownership Controller

This block decides when a self-started DMA channel may hold the system bus. Software programs a unit count and sets the enable. The controller then requests the bus and starts units one after another with no outside trigger, until the count runs out. A separate datapath moves one byte or word per unit and reports the end of each unit on `unit_done`. Address and data handling belong to that datapath and are not part of this block.

Two ownership policies are available. In cycle-steal mode the channel gives up the bus after every unit, so DMA units and CPU cycles alternate. In burst mode the channel keeps the bus from its first unit to its last. A request from a higher-priority master can still take the bus in burst mode, but only at a unit boundary. The channel asks for the bus again as soon as that request goes away. Once the last unit ends, a done flag rises and the channel stops requesting the bus.

Top module: `dma_bus_owner`

## Requirements
- R1: While reset is active and right after it, `dma_req`, `dma_gnt`, `unit_start` and `done` are all 0.
- R2: If `en` is sampled high while the controller is idle and `count` is non-zero, `count` is captured and `dma_req` goes high in the next cycle. If `hp_req` is low in that cycle, the first unit starts in the cycle after it, with `dma_gnt` and `unit_start` both high.
- R3: A unit starts in the cycle in which `unit_start` is high. It ends at the first later cycle in which `unit_done` is sampled high. `dma_gnt` stays high from the start of a unit to its end, and `unit_start` is high only when `dma_gnt` is high.
- R4: In cycle-steal mode (`burst_mode` = 0), after each unit that is not the last, `dma_gnt` is low for exactly one cycle, or for longer while `hp_req` is high. The next unit then starts.
- R5: In burst mode (`burst_mode` = 1), if a unit that is not the last ends while `hp_req` is low and `en` is high, the next unit starts in the very next cycle and `dma_gnt` stays high throughout.
- R6: In either mode, if `hp_req` is high when a unit that is not the last ends, `dma_gnt` drops in the next cycle. The channel then starts its next unit in the cycle after the first cycle in which `hp_req` is sampled low.
- R7: While the channel is waiting for the bus, any cycle in which `hp_req` is sampled high keeps `dma_gnt` low in the next cycle. `hp_req` never ends a unit that is in progress.
- R8: When the unit numbered `count` ends, the next cycle shows `done` = 1 and `dma_req` = `dma_gnt` = 0. `done` stays high until `en` is sampled low, and the controller is idle in the cycle after that.
- R9: A start with `count` = 0 runs no unit at all. `done` rises in the cycle after `en` is sampled.
- R10: `unit_done` has no effect outside the body of a unit, that is, when `dma_gnt` is low or in the `unit_start` cycle. It neither ends a unit nor counts toward `count`.
- R11: `cpu_gnt` equals `cpu_req` AND NOT `hp_req` AND NOT `dma_gnt` in the same cycle. It is never high together with `dma_gnt`.
- R12: Sampling `en` low while waiting for the bus, or at the end of a unit that is not the last, returns the controller to idle in the next cycle and starts no further unit. A later enable loads a fresh count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Channel enable; a start when sampled high in idle |
| burst_mode | input | 1 | 1 = burst retention, 0 = cycle-steal |
| count | input | CNT_W | Number of units, captured at start |
| hp_req | input | 1 | Bus request from a higher-priority master |
| cpu_req | input | 1 | Bus request from the CPU |
| unit_done | input | 1 | Datapath reports the end of the current unit |
| dma_req | output | 1 | Channel wants or holds the bus |
| dma_gnt | output | 1 | Channel owns the bus |
| cpu_gnt | output | 1 | CPU owns the bus |
| unit_start | output | 1 | First cycle of a unit |
| done | output | 1 | All units finished |

## Verification
Every registered result (`dma_req`, `dma_gnt`, `unit_start`, `done`) is due exactly one clock edge after the inputs that cause it are sampled. `cpu_gnt` is combinational and is due in the same cycle as its inputs. The bench changes inputs only at falling edges and steps its own requirement model at the rising edge that samples them. It then compares all outputs at the next falling edge, so each comparison falls in the first cycle in which the new value is due. `unit_done` is chosen after the current outputs have been observed. This lets the random runs put it both inside unit bodies and outside them, and the same one-cycle rule applies to the count and to `done`.

// File: rtl/dma_own_pkg.sv
package dma_own_pkg;
   typedef enum logic [1:0] {
      OWN_IDLE = 2'd0,
      OWN_WAIT = 2'd1,
      OWN_XFER = 2'd2,
      OWN_DONE = 2'd3
   } own_state_e;
endpackage

// File: rtl/dma_unit_cnt.sv
module dma_unit_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             last,
   output logic             load_zero
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rem_q <= '0;
      else if (load)
         rem_q <= load_val;
      else if (dec)
         rem_q <= rem_q - ONE;
   end

   assign last      = (rem_q == ONE);
   assign load_zero = (load_val == '0);
endmodule

// File: rtl/dma_own_fsm.sv
module dma_own_fsm
   import dma_own_pkg::*;
#(
   parameter int MIN_GAP = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       burst_mode,
   input  logic       hp_req,
   input  logic       unit_done,
   input  logic       last,
   input  logic       load_zero,
   output own_state_e state_q,
   output logic       starting_q,
   output logic       load,
   output logic       dec
);
   localparam int GAP_W = (MIN_GAP > 1) ? $clog2(MIN_GAP) + 1 : 1;

   generate
      if (MIN_GAP < 1) begin : g_bad_gap
         $error("dma_own_fsm: MIN_GAP must be at least 1");
      end
   endgenerate

   logic       gap_ok;
   own_state_e state_d;
   logic       start_d;
   logic       unit_end;

   // Minimum number of cycles spent off the bus before a unit may start.
   generate
      if (MIN_GAP <= 1) begin : g_gap_single
         assign gap_ok = 1'b1;
      end else begin : g_gap_count
         logic [GAP_W-1:0] gap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               gap_q <= '0;
            else if (state_q != OWN_WAIT)
               gap_q <= '0;
            else if (!gap_ok)
               gap_q <= gap_q + 1'b1;
         end
         assign gap_ok = (gap_q >= GAP_W'(MIN_GAP - 1));
      end
   endgenerate

   // A unit can end only after its start cycle.
   assign unit_end = (state_q == OWN_XFER) && !starting_q && unit_done;

   always_comb begin
      state_d = state_q;
      start_d = 1'b0;
      load    = 1'b0;
      dec     = 1'b0;
      case (state_q)
         OWN_IDLE: begin
            if (en) begin
               load    = 1'b1;
               state_d = load_zero ? OWN_DONE : OWN_WAIT;
            end
         end
         OWN_WAIT: begin
            if (!en)
               state_d = OWN_IDLE;
            else if (!hp_req && gap_ok) begin
               state_d = OWN_XFER;
               start_d = 1'b1;
            end
         end
         OWN_XFER: begin
            if (unit_end) begin
               dec = 1'b1;
               if (last)
                  state_d = OWN_DONE;
               else if (!en)
                  state_d = OWN_IDLE;
               else if (!burst_mode || hp_req)
                  state_d = OWN_WAIT;
               else
                  start_d = 1'b1;
            end
         end
         OWN_DONE: begin
            if (!en)
               state_d = OWN_IDLE;
         end
         default: state_d = OWN_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= OWN_IDLE;
         starting_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         starting_q <= start_d;
      end
   end
endmodule

// File: rtl/dma_bus_owner.sv
module dma_bus_owner
   import dma_own_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int MIN_GAP = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             burst_mode,
   input  logic [CNT_W-1:0] count,
   input  logic             hp_req,
   input  logic             cpu_req,
   input  logic             unit_done,
   output logic             dma_req,
   output logic             dma_gnt,
   output logic             cpu_gnt,
   output logic             unit_start,
   output logic             done
);
   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("dma_bus_owner: CNT_W must be at least 1");
      end
   endgenerate

   own_state_e state;
   logic       starting;
   logic       load;
   logic       dec;
   logic       last;
   logic       load_zero;

   dma_unit_cnt #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (count),
      .dec      (dec),
      .last     (last),
      .load_zero(load_zero)
   );

   dma_own_fsm #(
      .MIN_GAP(MIN_GAP)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .burst_mode(burst_mode),
      .hp_req    (hp_req),
      .unit_done (unit_done),
      .last      (last),
      .load_zero (load_zero),
      .state_q   (state),
      .starting_q(starting),
      .load      (load),
      .dec       (dec)
   );

   assign dma_gnt    = (state == OWN_XFER);
   assign dma_req    = (state == OWN_XFER) || (state == OWN_WAIT);
   assign unit_start = dma_gnt && starting;
   assign done       = (state == OWN_DONE);
   assign cpu_gnt    = cpu_req && !hp_req && !dma_gnt;
endmodule

// File: rtl/dma_bus_owner_chk.sv
module dma_bus_owner_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic burst_mode,
   input logic hp_req,
   input logic unit_done,
   input logic dma_req,
   input logic dma_gnt,
   input logic cpu_gnt,
   input logic unit_start,
   input logic done
);
   a_r11_gnt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(dma_gnt && cpu_gnt));

   a_r3_hold_mid_unit: assert property (@(posedge clk) disable iff (!rst_n)
      dma_gnt && (unit_start || !unit_done) |=> dma_gnt);

   a_r3_start_owned: assert property (@(posedge clk) disable iff (!rst_n)
      unit_start |-> dma_gnt);

   a_r4_steal_release: assert property (@(posedge clk) disable iff (!rst_n)
      dma_gnt && !unit_start && unit_done && !burst_mode |=> !dma_gnt);

   a_r6_preempt_release: assert property (@(posedge clk) disable iff (!rst_n)
      dma_gnt && !unit_start && unit_done && hp_req |=> !dma_gnt);

   a_r5_burst_chain: assert property (@(posedge clk) disable iff (!rst_n)
      dma_gnt && !unit_start && unit_done && burst_mode && !hp_req && en
      |=> (done || unit_start));

   a_r7_hp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_gnt && hp_req |=> !dma_gnt);

   a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !dma_req && !dma_gnt && !unit_start);
endmodule

bind dma_bus_owner dma_bus_owner_chk u_chk (.*);

// File: tb/tb_dma_bus_owner.sv
`timescale 1ns/1ps
module tb_dma_bus_owner;
   localparam int CNT_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic             en = 1'b0, burst_mode = 1'b0, hp_req = 1'b0;
   logic             cpu_req = 1'b0, unit_done = 1'b0;
   logic [CNT_W-1:0] count = '0;
   logic             dma_req, dma_gnt, cpu_gnt, unit_start, done;

   dma_bus_owner #(.CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .en(en), .burst_mode(burst_mode), .count(count),
      .hp_req(hp_req), .cpu_req(cpu_req), .unit_done(unit_done),
      .dma_req(dma_req), .dma_gnt(dma_gnt), .cpu_gnt(cpu_gnt),
      .unit_start(unit_start), .done(done)
   );

   int    checks = 0, errors = 0, cyc = 0;
   int    m_st = 0;        // 0 idle, 1 waiting, 2 owning, 3 finished
   bit    m_start = 1'b0;
   int    m_rem = 0;
   string m_tag = "R1";
   int    seen_units = 0;
   int    hp_left = 0;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL R2 watchdog: cycles %0d expected below %0d", cyc, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // Requirement model, advanced on the sampling edge.
   function automatic void model_adv();
      case (m_st)
         0: if (en) begin
               m_rem = int'(count);
               if (count == 0) begin m_st = 3; m_tag = "R9"; end
               else begin m_st = 1; m_tag = "R2"; end
            end
         1: if (!en) begin m_st = 0; m_tag = "R12"; end
            else if (!hp_req) begin m_st = 2; m_start = 1'b1; m_tag = "R2"; end
            else m_tag = "R7";
         2: if (m_start) begin
               m_start = 1'b0;
               m_tag = unit_done ? "R10" : "R3";
            end else if (unit_done) begin
               if (m_rem == 1) begin m_st = 3; m_tag = "R8"; end
               else begin
                  m_rem--;
                  if (!en) begin m_st = 0; m_tag = "R12"; end
                  else if (hp_req) begin m_st = 1; m_tag = "R6"; end
                  else if (!burst_mode) begin m_st = 1; m_tag = "R4"; end
                  else begin m_start = 1'b1; m_tag = "R5"; end
               end
            end else m_tag = "R3";
         default: if (!en) begin m_st = 0; m_tag = "R8"; end
      endcase
   endfunction

   task automatic compare();
      logic [3:0] exp_v, got_v;
      logic       e_gnt, e_cpu;
      e_gnt = (m_st == 2);
      exp_v = {(m_st == 1) || (m_st == 2), e_gnt, e_gnt && m_start, m_st == 3};
      got_v = {dma_req, dma_gnt, unit_start, done};
      checks++;
      if (got_v !== exp_v) begin
         errors++;
         $display("FAIL %s req/gnt/start/done got %b expected %b at cycle %0d",
                  m_tag, got_v, exp_v, cyc);
      end
      e_cpu = cpu_req && !hp_req && !e_gnt;
      checks++;
      if (cpu_gnt !== e_cpu) begin
         errors++;
         $display("FAIL R11 cpu_gnt got %b expected %b at cycle %0d", cpu_gnt, e_cpu, cyc);
      end
      if (unit_start === 1'b1) seen_units++;
   endtask

   task automatic step();
      @(posedge clk);
      if (rst_n) model_adv();
      @(negedge clk);
      compare();
   endtask

   task automatic drive(int hp_pct, bit cpu_always);
      if (hp_left > 0) begin
         hp_req = 1'b1;
         hp_left--;
      end else begin
         hp_req = 1'b0;
         if (int'($urandom % 100) < hp_pct) hp_left = 1 + int'($urandom % 5);
      end
      cpu_req = cpu_always ? 1'b1 : 1'($urandom % 2);
      // Inside a unit body end it sometimes; elsewhere stray pulses probe R10.
      if (dma_gnt && !unit_start) unit_done = ($urandom % 3) == 0;
      else                        unit_done = ($urandom % 4) == 0;
   endtask

   task automatic run(int cnt, bit bm, int hp_pct, bit cpu_always, int drop_after);
      count = CNT_W'(cnt);
      burst_mode = bm;
      en = 1'b1;
      seen_units = 0;
      for (int i = 0; i < 800; i++) begin
         if (done === 1'b1) break;
         if (drop_after >= 0 && i == drop_after) en = 1'b0;
         if (!en && dma_req === 1'b0 && i > drop_after) break;
         drive(hp_pct, cpu_always);
         step();
      end
      checks++;
      if (drop_after < 0) begin
         if (done !== 1'b1 || seen_units != cnt) begin
            errors++;
            $display("FAIL R8 done=%b units %0d expected done=1 units %0d", done, seen_units, cnt);
         end
      end else if (seen_units > cnt) begin
         errors++;
         $display("FAIL R12 units %0d expected at most %0d", seen_units, cnt);
      end
      en = 1'b0; hp_req = 1'b0; hp_left = 0; unit_done = 1'b0;
      step();
      step();
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      cpu_req = 1'b1;
      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         compare();
      end
      rst_n = 1'b1;
      step();
      cpu_req = 1'b0;
      run(0, 1'b1, 0, 1'b0, -1);   // R9 empty count
      run(1, 1'b1, 0, 1'b0, -1);   // R8 single unit
      run(5, 1'b0, 0, 1'b1, -1);   // R4 alternation with busy CPU
      run(7, 1'b1, 0, 1'b0, -1);   // R5 uninterrupted burst
      run(6, 1'b1, 45, 1'b0, -1);  // R6 preemption at boundaries
      run(6, 1'b0, 45, 1'b0, -1);  // R7 waits held off
      run(8, 1'b1, 0, 1'b0, 3);    // R12 early disable
      for (int r = 0; r < 80; r++) begin
         int  c;
         bit  b;
         int  hp;
         int  dr;
         c  = int'($urandom % 13);
         b  = 1'($urandom % 2);
         hp = int'($urandom % 30);
         dr = (($urandom % 6) == 0) ? int'($urandom % 20) : -1;
         run(c, b, hp, 1'($urandom % 2), dr);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule